// File: doc/BRIEF.md
# Accumulator ALU with Flag Generation

This block is the 8-bit arithmetic and logic core of a small accumulator processor. Each operation takes an opcode, a register operand `opnd_a`, a second operand `opnd_b` and an incoming carry, and produces a result in the same cycle. It also produces a write-back enable, the new N, Z, C and V values and a per-flag update mask. The operations are add and subtract with carry, AND, OR, XOR, the shift and rotate set, compare and bit test. A four-bit flag register holds N, Z, C and V. It takes the new values on a completed transfer and changes only the bits the mask selects.

Operations enter through a valid/ready pair and leave through a second one. There is no storage between the two sides. `out_valid` follows `in_valid` and `in_ready` follows `out_ready`, so the consumer's back-pressure reaches the producer in the same cycle. A transfer completes when `in_valid` and `out_ready` are both high. Only then does the flag register load. While the consumer stalls, the result stays visible but nothing is committed. Compare can be used with the accumulator, X or Y: the surrounding logic places the chosen register on `opnd_a`. Decimal arithmetic and operand fetch are not part of this block.

Flags are packed as {N, Z, C, V} in bit positions 3, 2, 1 and 0 of `flag_val`, `flag_mask` and `flags_q`. Opcodes: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 shift left, 6 logical shift right, 7 rotate left, 8 rotate right, 9 compare, 10 bit test. Codes 11 to 15 are unused.

Top module: `acc_alu`

## Requirements
- R1: Add (opcode 0) gives result = (a + b + carry_in) mod 256 and C = the carry out of bit 7.
- R2: Subtract (opcode 1) gives result = (a + ~b + carry_in) mod 256 and C = the carry out of bit 7, so C = 0 means a borrow occurred.
- R3: For add and subtract, V is 1 exactly when the two adder inputs (a and b for add, a and ~b for subtract) share a sign and the result's bit 7 differs from that sign; both operations update all four flags.
- R4: Opcodes 2, 3 and 4 give a AND b, a OR b and a XOR b, enable write-back, and update only N and Z.
- R5: Shift left (opcode 5) gives {a[6:0],0} and shift right (opcode 6) gives {0,a[7:1]}; C receives the bit shifted out; N, Z and C are updated.
- R6: Rotate left (opcode 7) gives {a[6:0],carry_in} and rotate right (opcode 8) gives {carry_in,a[7:1]}; C receives the bit shifted out; N, Z and C are updated.
- R7: Compare (opcode 9) outputs (a - b) mod 256 as result with write-back disabled, sets C when a >= b, sets Z when a == b, N from result bit 7, and leaves V unchanged.
- R8: Bit test (opcode 10) outputs a AND b with write-back disabled, sets N = b[7], V = b[6], Z = 1 when a AND b is zero, and leaves C unchanged.
- R9: For every opcode except bit test, updated N equals result bit 7 and updated Z is 1 exactly when the result is zero.
- R10: For each opcode `flag_val` carries the new value in masked bits and the stored flag in unmasked bits; opcodes 11 to 15 give result 0, no write-back, mask 0.
- R11: `flags_q` resets to 0000 and loads `flag_val` only on a cycle with `in_valid` and `out_ready` both high; otherwise it holds.
- R12: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the flag register |
| in_valid | input | 1 | Operation presented |
| in_ready | output | 1 | Operation accepted this cycle (mirrors out_ready) |
| op | input | 4 | Operation code |
| opnd_a | input | 8 | Register operand (accumulator, X or Y) |
| opnd_b | input | 8 | Second operand |
| carry_in | input | 1 | Incoming carry for add, subtract and rotates |
| out_valid | output | 1 | Result valid (mirrors in_valid) |
| out_ready | input | 1 | Consumer can take the result |
| result | output | 8 | Operation result |
| wr_en | output | 1 | Result is to be written back |
| flag_val | output | 4 | Flags as they become after this operation, {N,Z,C,V} |
| flag_mask | output | 4 | Flags this operation updates, {N,Z,C,V} |
| flags_q | output | 4 | Stored flag register, {N,Z,C,V} |

## Verification
The in-module properties assume that `op`, the operands and `carry_in` are known whenever `in_valid` is high. They also assume that a cycle with `in_valid` low says nothing about the result. The bench first holds `in_valid` low and sweeps all 256 values of `opnd_a` against 89 values of `opnd_b`, every opcode and both carries. Only the combinational outputs are checked in that sweep, because the flag register cannot change. It then raises `in_valid` in a short directed sequence driven on falling edges. That sequence commits flags, stalls the consumer and checks that the masked bits hold.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_ASL = 4'd5,
    OP_LSR = 4'd6,
    OP_ROL = 4'd7,
    OP_ROR = 4'd8,
    OP_CMP = 4'd9,
    OP_BIT = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_ASL = 2'd0,
    SH_LSR = 2'd1,
    SH_ROL = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_kind_e;

  // positions inside the packed {N,Z,C,V} nibble
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;
  localparam int FLAG_W = 4;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         inv_b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W:0]   total;

  assign b_eff = inv_b ? ~b : b;
  assign total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign sum   = total[W-1:0];
  assign cout  = total[W];
  // signed overflow: like-signed inputs, result sign flipped
  assign ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  input  shift_kind_e  kind,
  output logic [W-1:0] res,
  output logic         cout
);
  always_comb begin
    unique case (kind)
      SH_ASL: begin res = {a[W-2:0], 1'b0}; cout = a[W-1]; end
      SH_LSR: begin res = {1'b0, a[W-1:1]}; cout = a[0];   end
      SH_ROL: begin res = {a[W-2:0], cin};  cout = a[W-1]; end
      SH_ROR: begin res = {cin, a[W-1:1]};  cout = a[0];   end
      default: begin res = '0; cout = 1'b0; end
    endcase
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_kind_e  kind,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (kind)
      LG_AND:  res = a & b;
      LG_OR:   res = a | b;
      LG_XOR:  res = a ^ b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [3:0]   op,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         carry_in,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic [3:0]   flag_val,
  output logic [3:0]   flag_mask,
  output logic [3:0]   flags_q
);
  alu_op_e     op_e;
  logic        as_inv, as_cin, as_cout, as_ovf;
  logic [W-1:0] as_sum, sh_res, lg_res;
  logic        sh_cout;
  shift_kind_e sh_kind;
  logic_kind_e lg_kind;
  logic [FLAG_W-1:0] flag_new;
  logic        fire;

  assign op_e = alu_op_e'(op);

  // operand steering for the shared units
  always_comb begin
    as_inv  = (op_e != OP_ADD);
    as_cin  = (op_e == OP_CMP) ? 1'b1 : carry_in;
    unique case (op_e)
      OP_LSR:  sh_kind = SH_LSR;
      OP_ROL:  sh_kind = SH_ROL;
      OP_ROR:  sh_kind = SH_ROR;
      default: sh_kind = SH_ASL;
    endcase
    unique case (op_e)
      OP_OR:   lg_kind = LG_OR;
      OP_XOR:  lg_kind = LG_XOR;
      default: lg_kind = LG_AND;
    endcase
  end

  alu_addsub #(.W(W)) u_addsub (
    .a(opnd_a), .b(opnd_b), .inv_b(as_inv), .cin(as_cin),
    .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
  );

  alu_shift #(.W(W)) u_shift (
    .a(opnd_a), .cin(carry_in), .kind(sh_kind),
    .res(sh_res), .cout(sh_cout)
  );

  alu_logic #(.W(W)) u_logic (
    .a(opnd_a), .b(opnd_b), .kind(lg_kind), .res(lg_res)
  );

  // result select, write-back and per-flag masks
  always_comb begin
    result    = '0;
    wr_en     = 1'b0;
    flag_mask = 4'b0000;
    flag_new  = '0;
    unique case (op_e)
      OP_ADD, OP_SUB: begin
        result = as_sum; wr_en = 1'b1; flag_mask = 4'b1111;
        flag_new[FLAG_C] = as_cout;
        flag_new[FLAG_V] = as_ovf;
      end
      OP_AND, OP_OR, OP_XOR: begin
        result = lg_res; wr_en = 1'b1; flag_mask = 4'b1100;
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        result = sh_res; wr_en = 1'b1; flag_mask = 4'b1110;
        flag_new[FLAG_C] = sh_cout;
      end
      OP_CMP: begin
        result = as_sum; flag_mask = 4'b1110;
        flag_new[FLAG_C] = as_cout;
      end
      OP_BIT: begin
        result = lg_res; flag_mask = 4'b1101;
      end
      default: ;
    endcase
    if (op_e == OP_BIT) begin
      flag_new[FLAG_N] = opnd_b[W-1];
      flag_new[FLAG_V] = opnd_b[W-2];
      flag_new[FLAG_Z] = (lg_res == '0);
    end else begin
      flag_new[FLAG_N] = result[W-1];
      flag_new[FLAG_Z] = (result == '0);
    end
    flag_val = (flag_new & flag_mask) | (flags_q & ~flag_mask);
  end

  // pass-through handshake, flags commit on a completed transfer
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign fire      = in_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)    flags_q <= '0;
    else if (fire) flags_q <= flag_val;
  end

  AST_SUB_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_e == OP_SUB |-> flag_val[FLAG_V] ==
      ((opnd_a[W-1] != opnd_b[W-1]) && (result[W-1] != opnd_a[W-1]))); // R3
  AST_CMP_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_e == OP_CMP |-> !wr_en && flag_mask[FLAG_V] == 1'b0); // R7
  AST_CMP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op_e == OP_CMP |=> flags_q[FLAG_C] == $past(opnd_a >= opnd_b)); // R7
  AST_BIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_e == OP_BIT |-> !wr_en && flag_val[FLAG_N] == opnd_b[W-1]
      && flag_val[FLAG_V] == opnd_b[W-2]); // R8
  AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && wr_en |-> flag_val[FLAG_Z] == (result == '0)); // R9
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((flags_q ^ $past(flags_q)) & ~$past(flag_mask)) == 4'b0000); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(flags_q)); // R11
endmodule

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] op_i = 4'd0;
  logic [7:0] a_i = 8'd0;
  logic [7:0] b_i = 8'd0;
  logic       c_i = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] result;
  logic       wr_en;
  logic [3:0] flag_val, flag_mask, flags_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op_i), .opnd_a(a_i), .opnd_b(b_i), .carry_in(c_i),
    .out_valid(out_valid), .out_ready(out_ready), .result(result),
    .wr_en(wr_en), .flag_val(flag_val), .flag_mask(flag_mask), .flags_q(flags_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0: return "R1 R3 R9";
      1: return "R2 R3 R9";
      2, 3, 4: return "R4 R9";
      5, 6: return "R5 R9";
      7, 8: return "R6 R9";
      9: return "R7";
      10: return "R8";
      default: return "R10";
    endcase
  endfunction

  // arithmetic reference: packs {result, wr, mask, val}
  function automatic logic [16:0] model(input int op, input int a, input int b,
                                        input int c, input int fq);
    int res, wr, mask, n, z, cf, v, s, nzcv, val;
    res = 0; wr = 0; mask = 0; cf = 0; v = 0;
    case (op)
      0: begin s = a + b + c; res = s % 256; cf = s / 256; wr = 1; mask = 15;
               v = ((a >= 128) == (b >= 128) && (res >= 128) != (a >= 128)) ? 1 : 0; end
      1: begin s = a + (255 - b) + c; res = s % 256; cf = s / 256; wr = 1; mask = 15;
               v = ((a >= 128) != (b >= 128) && (res >= 128) != (a >= 128)) ? 1 : 0; end
      2: begin res = a & b; wr = 1; mask = 12; end
      3: begin res = a | b; wr = 1; mask = 12; end
      4: begin res = a ^ b; wr = 1; mask = 12; end
      5: begin res = (a * 2) % 256; cf = a / 128; wr = 1; mask = 14; end
      6: begin res = a / 2; cf = a % 2; wr = 1; mask = 14; end
      7: begin res = (a * 2) % 256 + c; cf = a / 128; wr = 1; mask = 14; end
      8: begin res = a / 2 + c * 128; cf = a % 2; wr = 1; mask = 14; end
      9: begin res = (a - b + 256) % 256; cf = (a >= b) ? 1 : 0; mask = 14; end
      10: begin res = a & b; mask = 13; v = (b / 64) % 2; end
      default: ;
    endcase
    n = (op == 10) ? b / 128 : res / 128;
    z = (res == 0) ? 1 : 0;
    nzcv = n * 8 + z * 4 + cf * 2 + v;
    val  = (nzcv & mask) | (fq & ~mask & 15);
    return {res[7:0], wr[0], mask[3:0], val[3:0]};
  endfunction

  task automatic drive(input int op, input int a, input int b, input int c,
                       input bit v, input bit rdy);
    @(negedge clk);
    op_i = op[3:0]; a_i = a[7:0]; b_i = b[7:0]; c_i = c[0];
    in_valid = v; out_ready = rdy;
    #1;
  endtask

  task automatic commit_and_check(input string tag, input logic [3:0] exp_flags);
    @(posedge clk); #1;
    chk(tag, {28'd0, flags_q}, {28'd0, exp_flags});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset flags", {28'd0, flags_q}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // combinational sweep with in_valid low: flag register must stay at zero
    for (int op = 0; op < 16; op++) begin
      for (int c = 0; c < 2; c++) begin
        for (int a = 0; a < 256; a++) begin
          for (int bi = 0; bi < 89; bi++) begin
            int b;
            b = (bi < 86) ? bi * 3 : (bi == 86 ? 127 : (bi == 87 ? 128 : 1));
            op_i = op[3:0]; a_i = a[7:0]; b_i = b[7:0]; c_i = c[0];
            #0.5;
            chk(tag_of(op), {15'd0, result, wr_en, flag_mask, flag_val},
                {15'd0, model(op, a, b, c, 0)});
            #0.5;
          end
        end
      end
    end
    chk("R11 idle sweep kept flags", {28'd0, flags_q}, 32'd0);

    // directed flag-file sequence
    drive(0, 8'h7F, 8'h01, 0, 1, 1);
    chk("R12 valid mirror", {30'd0, out_valid, in_ready}, 32'd3);
    commit_and_check("R11 R3 add overflow commit", 4'b1001);
    drive(2, 8'hFF, 8'h00, 0, 1, 1);
    commit_and_check("R4 and keeps C V", 4'b0101);
    drive(0, 8'h80, 8'h80, 0, 1, 0);
    chk("R12 stall ready low", {30'd0, out_valid, in_ready}, 32'd2);
    commit_and_check("R11 stall no commit", 4'b0101);
    drive(1, 8'h00, 8'h01, 0, 0, 1);
    chk("R12 idle valid low", {30'd0, out_valid, in_ready}, 32'd1);
    commit_and_check("R11 invalid no commit", 4'b0101);
    drive(9, 8'h05, 8'h03, 0, 1, 1);
    chk("R7 compare no write", {31'd0, wr_en}, 32'd0);
    commit_and_check("R7 compare keeps V", 4'b0011);
    drive(10, 8'h0F, 8'hC0, 0, 1, 1);
    chk("R8 bit result", {24'd0, result}, 32'h00);
    commit_and_check("R8 bit copies N V keeps C", 4'b1111);
    drive(8, 8'h01, 8'h00, 1, 1, 1);
    chk("R6 rotate right result", {24'd0, result}, 32'h80);
    commit_and_check("R6 rotate right flags", 4'b1011);
    drive(15, 8'h00, 8'h00, 0, 1, 1);
    commit_and_check("R10 unused opcode no update", 4'b1011);
    drive(6, 8'h01, 8'h00, 0, 1, 1);
    commit_and_check("R5 shift right to zero", 4'b0111);
    drive(0, 8'h00, 8'h00, 0, 0, 1);
    rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R11 reset clears flags", {28'd0, flags_q}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule